// File: doc/BRIEF.md
# Load-Linked Reservation Capture Unit

This unit serves the load-linked word and doubleword operations of a pipelined core. A request carries a virtual address, the physical address that translation has already produced for it, a size select and the core's debug-mode flag. The unit first checks the virtual address for natural alignment. A misaligned request raises an address-error-on-load exception and starts no memory read. The faulting address is kept in a bad-address register, unless the core is in debug mode.

An aligned request issues one read on a memory port whose data comes back in the following cycle. When that data arrives, the unit extends it to the register width. A word is sign-extended from bit 31. A doubleword passes through as it is. The unit then commits the physical address, the virtual address and the extended value as the reservation, and returns the same value as the load result. The reservation registers stay visible as outputs, so that a later conditional-store stage can compare against them.

The request side uses valid/ready. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is low for the one cycle in which a read is outstanding. A requester that sees `req_ready` low must hold its request until `req_ready` returns high. The result side is a pair of one-cycle pulses, `resp_done` and `resp_addr_err`, and neither can be stalled.

Top module: `llc_top`

## Requirements
- R1: A word request (`req_dbl`=0) is misaligned when either of virtual address bits [1:0] is set; bit 2 has no effect on a word request.
- R2: A doubleword request (`req_dbl`=1) is misaligned when any of virtual address bits [2:0] is set.
- R3: A misaligned request that is accepted drives `resp_addr_err` high for exactly the one cycle after acceptance. It issues no memory read, does not assert `resp_done`, and leaves the link registers unchanged.
- R4: On a misaligned acceptance with `dbg_mode`=0, `bad_vaddr` takes the request's virtual address in the next cycle. With `dbg_mode`=1, `bad_vaddr` keeps its value.
- R5: An aligned request asserts `mem_rd_en` in its acceptance cycle, with `mem_rd_addr` equal to `req_paddr` and `mem_rd_dbl` equal to `req_dbl`.
- R6: When `resp_done` is high, `link_paddr` and `link_vaddr` hold the physical and virtual addresses of the completed request.
- R7: A word result is `mem_rd_data[31:0]` sign-extended to XLEN bits. A doubleword result equals `mem_rd_data`.
- R8: `resp_done` is high for exactly one cycle, two cycles after acceptance. In that cycle `resp_data` equals `link_value`, and `resp_done` and `resp_addr_err` are never high together.
- R9: `req_ready` is low in the cycle after a memory read is issued and high otherwise, so a request held during that cycle is not accepted until the next one.
- R10: After reset, `link_paddr`, `link_vaddr`, `link_value` and `bad_vaddr` are zero, `req_ready` is high, and both response pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | XLEN | Untranslated address of the request |
| req_paddr | input | PA_W | Translated physical address |
| req_dbl | input | 1 | 1 = doubleword, 0 = word |
| dbg_mode | input | 1 | Core is in debug mode |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | PA_W | Memory read physical address |
| mem_rd_dbl | output | 1 | Memory read size, 1 = doubleword |
| mem_rd_data | input | XLEN | Read data, valid the cycle after the strobe |
| resp_done | output | 1 | One-cycle pulse: load finished |
| resp_addr_err | output | 1 | One-cycle pulse: address-error-on-load |
| resp_data | output | XLEN | Load result |
| bad_vaddr | output | XLEN | Last faulting address captured |
| link_paddr | output | PA_W | Reservation physical address |
| link_vaddr | output | XLEN | Reservation virtual address |
| link_value | output | XLEN | Reservation value |

## Verification
A wrong state in the control register shows at `req_ready` in the very next cycle. It also shows as a missing or doubled `resp_done` one cycle after that. A wrong captured address or size shows on the link outputs and on the extended result in the `resp_done` cycle, two cycles after acceptance. A wrong alignment or debug decision shows one cycle after acceptance, in one of three ways: a spurious memory read, a missing `resp_addr_err`, or a `bad_vaddr` that moved when it should have held.

// File: rtl/llc_pkg.sv
package llc_pkg;
  typedef enum logic {
    LLC_IDLE = 1'b0,
    LLC_WAIT = 1'b1
  } llc_state_t;

  localparam int unsigned LLC_WORD_W = 32;
  localparam int unsigned LLC_WORD_LSB_BITS = 2;
  localparam int unsigned LLC_DBL_LSB_BITS = 3;
endpackage

// File: rtl/llc_align_chk.sv
module llc_align_chk
  import llc_pkg::*;
(
  input  logic [LLC_DBL_LSB_BITS-1:0] addr_lsb,
  input  logic                        is_dbl,
  output logic                        misaligned
);
  logic word_bad;
  logic dbl_bad;

  assign word_bad   = |addr_lsb[LLC_WORD_LSB_BITS-1:0];
  assign dbl_bad    = |addr_lsb;
  assign misaligned = is_dbl ? dbl_bad : word_bad;
endmodule

// File: rtl/llc_extend.sv
module llc_extend #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] raw,
  input  logic            is_dbl,
  output logic [XLEN-1:0] extended
);
  import llc_pkg::*;
  localparam int unsigned HI_W = (XLEN > LLC_WORD_W) ? XLEN - LLC_WORD_W : 1;

  generate
    if (XLEN > LLC_WORD_W) begin : g_wide
      logic [XLEN-1:0] word_ext;
      assign word_ext = {{HI_W{raw[LLC_WORD_W-1]}}, raw[LLC_WORD_W-1:0]};
      assign extended = is_dbl ? raw : word_ext;
    end else begin : g_narrow
      logic unused_sel;
      assign unused_sel = is_dbl;
      assign extended   = raw;
    end
  endgenerate
endmodule

// File: rtl/llc_ctrl.sv
module llc_ctrl
  import llc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic misaligned,
  output logic req_ready,
  output logic take_good,
  output logic take_bad,
  output logic data_phase
);
  llc_state_t state_q;
  llc_state_t state_d;

  assign req_ready  = (state_q == LLC_IDLE);
  assign take_good  = req_valid && req_ready && !misaligned;
  assign take_bad   = req_valid && req_ready && misaligned;
  assign data_phase = (state_q == LLC_WAIT);

  always_comb begin
    state_d = state_q;
    case (state_q)
      LLC_IDLE: if (take_good) state_d = LLC_WAIT;
      LLC_WAIT: state_d = LLC_IDLE;
      default:  state_d = LLC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LLC_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/llc_top.sv
module llc_top
  import llc_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned PA_W = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [XLEN-1:0] req_vaddr,
  input  logic [PA_W-1:0] req_paddr,
  input  logic            req_dbl,
  input  logic            dbg_mode,
  output logic            mem_rd_en,
  output logic [PA_W-1:0] mem_rd_addr,
  output logic            mem_rd_dbl,
  input  logic [XLEN-1:0] mem_rd_data,
  output logic            resp_done,
  output logic            resp_addr_err,
  output logic [XLEN-1:0] resp_data,
  output logic [XLEN-1:0] bad_vaddr,
  output logic [PA_W-1:0] link_paddr,
  output logic [XLEN-1:0] link_vaddr,
  output logic [XLEN-1:0] link_value
);
  logic            misaligned;
  logic            take_good;
  logic            take_bad;
  logic            data_phase;
  logic [XLEN-1:0] ext_data;
  logic [PA_W-1:0] pend_paddr;
  logic [XLEN-1:0] pend_vaddr;
  logic            pend_dbl;

  llc_align_chk u_align (
    .addr_lsb   (req_vaddr[LLC_DBL_LSB_BITS-1:0]),
    .is_dbl     (req_dbl),
    .misaligned (misaligned)
  );

  llc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .misaligned (misaligned),
    .req_ready  (req_ready),
    .take_good  (take_good),
    .take_bad   (take_bad),
    .data_phase (data_phase)
  );

  llc_extend #(.XLEN(XLEN)) u_ext (
    .raw      (mem_rd_data),
    .is_dbl   (pend_dbl),
    .extended (ext_data)
  );

  assign mem_rd_en   = take_good;
  assign mem_rd_addr = req_paddr;
  assign mem_rd_dbl  = req_dbl;
  assign resp_data   = link_value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_paddr <= '0;
      pend_vaddr <= '0;
      pend_dbl   <= 1'b0;
    end else if (take_good) begin
      pend_paddr <= req_paddr;
      pend_vaddr <= req_vaddr;
      pend_dbl   <= req_dbl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_paddr <= '0;
      link_vaddr <= '0;
      link_value <= '0;
    end else if (data_phase) begin
      link_paddr <= pend_paddr;
      link_vaddr <= pend_vaddr;
      link_value <= ext_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_vaddr <= '0;
    end else if (take_bad && !dbg_mode) begin
      bad_vaddr <= req_vaddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_done     <= 1'b0;
      resp_addr_err <= 1'b0;
    end else begin
      resp_done     <= data_phase;
      resp_addr_err <= take_bad;
    end
  end
endmodule

// File: rtl/llc_checker.sv
module llc_checker #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [XLEN-1:0] req_vaddr,
  input logic            req_dbl,
  input logic            dbg_mode,
  input logic            mem_rd_en,
  input logic            resp_done,
  input logic            resp_addr_err,
  input logic [XLEN-1:0] bad_vaddr
);
  logic chk_misal;
  logic chk_take_bad;

  assign chk_misal    = req_dbl ? (req_vaddr[2:0] != 3'd0) : (req_vaddr[1:0] != 2'd0);
  assign chk_take_bad = req_valid && req_ready && chk_misal;

  p_no_read_misaligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_take_bad |-> !mem_rd_en);

  p_err_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_addr_err |=> !resp_addr_err);

  p_bad_hold_dbg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_take_bad && dbg_mode) |=> $stable(bad_vaddr));

  p_bad_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_take_bad && !dbg_mode) |=> (bad_vaddr == $past(req_vaddr)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done);

  p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |-> !resp_addr_err);

  p_backpressure_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !req_ready);
endmodule

bind llc_top llc_checker #(.XLEN(XLEN)) u_llc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .req_dbl       (req_dbl),
  .dbg_mode      (dbg_mode),
  .mem_rd_en     (mem_rd_en),
  .resp_done     (resp_done),
  .resp_addr_err (resp_addr_err),
  .bad_vaddr     (bad_vaddr)
);

// File: tb/llc_top_test.sv
module llc_top_test;
  localparam int XLEN = 64;
  localparam int PA_W = 40;
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [XLEN-1:0] req_vaddr = '0;
  logic [PA_W-1:0] req_paddr = '0;
  logic            req_dbl = 1'b0;
  logic            dbg_mode = 1'b0;
  logic            mem_rd_en;
  logic [PA_W-1:0] mem_rd_addr;
  logic            mem_rd_dbl;
  logic [XLEN-1:0] mem_rd_data = '0;
  logic            resp_done;
  logic            resp_addr_err;
  logic [XLEN-1:0] resp_data;
  logic [XLEN-1:0] bad_vaddr;
  logic [PA_W-1:0] link_paddr;
  logic [XLEN-1:0] link_vaddr;
  logic [XLEN-1:0] link_value;

  int checks = 0;
  int errors = 0;

  logic [XLEN-1:0] mem_pattern = '0;
  logic [PA_W-1:0] seen_addr = '0;
  logic            seen_dbl = 1'b0;
  int              rd_count = 0;

  logic [XLEN-1:0] exp_bad = '0;
  logic [PA_W-1:0] exp_lp = '0;
  logic [XLEN-1:0] exp_lv = '0;
  logic [XLEN-1:0] exp_val = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  llc_top #(.XLEN(XLEN), .PA_W(PA_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_paddr(req_paddr), .req_dbl(req_dbl),
    .dbg_mode(dbg_mode), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_dbl(mem_rd_dbl), .mem_rd_data(mem_rd_data), .resp_done(resp_done),
    .resp_addr_err(resp_addr_err), .resp_data(resp_data), .bad_vaddr(bad_vaddr),
    .link_paddr(link_paddr), .link_vaddr(link_vaddr), .link_value(link_value)
  );

  // single-cycle-response memory model
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= mem_pattern;
      seen_addr   <= mem_rd_addr;
      seen_dbl    <= mem_rd_dbl;
      rd_count    <= rd_count + 1;
    end
  end

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [XLEN-1:0] va, input logic [PA_W-1:0] pa,
                         input logic dbl, input logic dbg, input logic [XLEN-1:0] pat);
    logic bad;
    int   rc0;
    bad = dbl ? (va[2:0] != 3'd0) : (va[1:0] != 2'd0);
    @(negedge clk);
    check("R9 ready when idle", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_vaddr = va; req_paddr = pa; req_dbl = dbl; dbg_mode = dbg;
    mem_pattern = pat;
    rc0 = rd_count;
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      if (!dbg) exp_bad = va;
      check(dbl ? "R2 R3 error pulse" : "R1 R3 error pulse", {63'd0, resp_addr_err}, 64'd1);
      check("R3 no memory read", 64'(rd_count - rc0), 64'd0);
      check("R3 no done", {63'd0, resp_done}, 64'd0);
      check("R4 bad address", bad_vaddr, exp_bad);
      check("R3 link vaddr kept", link_vaddr, exp_lv);
      check("R3 link value kept", link_value, exp_val);
      @(negedge clk);
      check("R3 error one cycle", {63'd0, resp_addr_err}, 64'd0);
    end else begin
      exp_lp = pa; exp_lv = va;
      exp_val = dbl ? pat : {{32{pat[31]}}, pat[31:0]};
      check(dbl ? "R2 R5 one read" : "R1 R5 one read", 64'(rd_count - rc0), 64'd1);
      check("R5 read address", 64'(seen_addr), 64'(pa));
      check("R5 read size", {63'd0, seen_dbl}, {63'd0, dbl});
      check("R9 back-pressure", {63'd0, req_ready}, 64'd0);
      check("R3 no error", {63'd0, resp_addr_err}, 64'd0);
      @(negedge clk);
      check("R8 done", {63'd0, resp_done}, 64'd1);
      check("R7 result", resp_data, exp_val);
      check("R8 link value", link_value, exp_val);
      check("R6 link paddr", 64'(link_paddr), 64'(exp_lp));
      check("R6 link vaddr", link_vaddr, exp_lv);
      @(negedge clk);
      check("R8 done one cycle", {63'd0, resp_done}, 64'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 link paddr", 64'(link_paddr), 64'd0);
    check("R10 link vaddr", link_vaddr, '0);
    check("R10 link value", link_value, '0);
    check("R10 bad vaddr", bad_vaddr, '0);
    check("R10 ready", {63'd0, req_ready}, 64'd1);
    check("R10 pulses", {62'd0, resp_done, resp_addr_err}, 64'd0);
    for (int idx = 0; idx < 32; idx++) begin
      logic [2:0] off;
      logic [XLEN-1:0] va;
      logic [PA_W-1:0] pa;
      logic [XLEN-1:0] pat;
      off = idx[2:0];
      va  = 64'hFFFF_8000_0000_1000 + 64'(idx << 4) + 64'(off);
      pa  = 40'h12_3450_0000 + 40'(idx << 4) + 40'(off);
      pat = {32'hC0DE_0000 + 32'(idx), (idx[3] ^ idx[0]) ? 32'h8765_4321 + 32'(idx) : 32'h1234_5678 + 32'(idx)};
      run_req(va, pa, idx[3], idx[4], pat);
    end
    // debug-mode misalign after a capture keeps the earlier bad address (R4)
    run_req(64'h0000_0000_0000_0002, 40'h2, 1'b0, 1'b0, '0);
    run_req(64'h0000_0000_0000_0005, 40'h5, 1'b1, 1'b1, '0);
    // word at offset 4 is aligned (R1), negative word extends (R7)
    run_req(64'h0000_0000_0000_0F04, 40'hF04, 1'b0, 1'b0, 64'h1111_2222_FFFF_FFFE);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule